// File: doc/BRIEF.md
# Dual-Format Serial Clock Prescaler

This block produces the serial clock timing for an SPI shift engine from the system clock. An 8-bit rate field selects the divisor, read in one of two layouts. The choice of layout comes from a format input. The legacy layout gives even divisors from 4 to 30. The extended layout multiplies a 4-bit linear factor by a power of two whose 3-bit exponent is split across non-adjacent field bits. Because of that split, the divisor can be odd, and it can be as large as 1920.

While the run input is high, the block emits a one-cycle strobe at the end of each half of the serial clock period. A lead strobe marks the end of the idle-level half, and a trail strobe marks the end of the active-level half. The block also drives a registered serial clock. That clock rests at a selectable idle level whenever run is low. The rate field, the format and the idle level are captured once, on the cycle run rises, so a word never changes speed part way through. A setting that cannot produce a usable clock raises an error flag for as long as run is high, and no strobes are produced.

Top module: `sck_prescaler`

## Requirements
- R1: With `ext_fmt`=0 the divisor is D = 2*N, where N = `rate_field[3:0]`; `rate_field[7:4]` has no effect.
- R2: With `ext_fmt`=1 the divisor is D = S * 2^E. S = `rate_field[3:0]`. E = {`rate_field[7]`, `rate_field[6]`, `rate_field[4]`}, with `rate_field[7]` as the most significant bit and `rate_field[4]` as the least. `rate_field[5]` has no effect.
- R3: A legacy setting with N < 2, or an extended setting with D < 2, is invalid. While run is high after capture, `cfg_err` is 1, both strobes stay 0 and `sck` stays at the captured idle level.
- R4: Let the capture edge be the first rising clock edge at which `run` is 1, and call the cycle after it cycle 1. `lead_tick` is high in cycle floor(D/2). `trail_tick` is high in cycle D. The pattern repeats every D cycles, and the two strobes are never high together.
- R5: `sck` holds the captured idle level up to and including the lead strobe cycle. It takes the opposite level from the next cycle through the trail strobe cycle, and returns to the idle level after that.
- R6: At the first clock edge that samples `run`=0, the strobes stop and `cfg_err` drops. At that same edge `sck` takes the current `idle_hi` value.
- R7: Changes to `rate_field`, `ext_fmt` or `idle_hi` while `run` stays high do not alter the strobe timing or the `sck` levels of the running word.
- R8: After a synchronous reset, both strobes and `cfg_err` are 0 and `sck` equals `idle_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Word active; low clears the timer and parks the clock |
| ext_fmt | input | 1 | 0 selects the legacy layout, 1 the extended layout |
| rate_field | input | 8 | Rate setting, captured when run rises |
| idle_hi | input | 1 | Idle level of the serial clock |
| lead_tick | output | 1 | End of the idle-level half period |
| trail_tick | output | 1 | End of the active-level half period |
| sck | output | 1 | Serial clock waveform |
| cfg_err | output | 1 | Captured setting is invalid |

## Verification
Suppose the captured divisor or the half-period counter were wrong. The first lead strobe would then land in the wrong cycle, within at most floor(D/2) cycles of the capture edge. If the phase bit were wrong, `sck` would show the wrong level in the very next cycle. A decode error in the split exponent bits changes the divisor by a power of two, so sweeping every field value in both layouts exposes each such bit on its own. Changing the inputs right after capture makes any leak from the live inputs appear as moved strobes within the same word.

// File: rtl/sck_psc_pkg.sv
package sck_psc_pkg;
    localparam int FIELD_W     = 8;
    localparam int SPR_W       = 4;
    localparam int SPPR_W      = 3;
    localparam int DIV_W       = SPR_W + (1 << SPPR_W) - 1;
    localparam int LEG_MIN_N   = 2;
    localparam int EXT_MIN_DIV = 2;

    typedef logic [DIV_W-1:0] div_t;

    typedef enum logic {
        FMT_LEGACY = 1'b0,
        FMT_EXT    = 1'b1
    } fmt_e;

    typedef struct packed {
        div_t div;
        logic ok;
    } rate_t;

    typedef struct packed {
        rate_t rate;
        logic  cpol;
    } word_cfg_t;

    function automatic rate_t decode_field(fmt_e fmt, logic [FIELD_W-1:0] f);
        rate_t             r;
        logic [SPPR_W-1:0] e;
        e = {f[7], f[6], f[4]};
        if (fmt == FMT_LEGACY) begin
            r.div = div_t'({f[SPR_W-1:0], 1'b0});
            r.ok  = (int'(f[SPR_W-1:0]) >= LEG_MIN_N);
        end else begin
            r.div = div_t'(f[SPR_W-1:0]) << e;
            r.ok  = (int'(r.div) >= EXT_MIN_DIV);
        end
        return r;
    endfunction
endpackage

// File: rtl/psc_decode.sv
module psc_decode
    import sck_psc_pkg::*;
(
    input  fmt_e               fmt,
    input  logic [FIELD_W-1:0] field,
    output rate_t              rate
);
    always_comb begin
        rate = decode_field(fmt, field);
    end
endmodule

// File: rtl/psc_timer.sv
module psc_timer
    import sck_psc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  rate_t rate_in,
    input  logic  cpol_in,
    output logic  lead,
    output logic  trail,
    output logic  active,
    output logic  bad,
    output logic  cpol_q
);
    word_cfg_t cfg_q;
    logic      act_q;
    logic      ph_q;
    div_t      cnt_q;
    div_t      lo_len;
    div_t      hi_len;
    div_t      cur_len;
    logic      hit;

    always_comb begin
        lo_len  = cfg_q.rate.div >> 1;
        hi_len  = cfg_q.rate.div - lo_len;
        cur_len = ph_q ? hi_len : lo_len;
        hit     = act_q && cfg_q.rate.ok && (cnt_q == cur_len);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            ph_q  <= 1'b0;
            cnt_q <= '0;
            cfg_q <= '0;
        end else if (!run) begin
            act_q <= 1'b0;
            ph_q  <= 1'b0;
            cnt_q <= '0;
        end else if (!act_q) begin
            act_q      <= 1'b1;
            ph_q       <= 1'b0;
            cnt_q      <= div_t'(1);
            cfg_q.rate <= rate_in;
            cfg_q.cpol <= cpol_in;
        end else if (hit) begin
            cnt_q <= div_t'(1);
            ph_q  <= ~ph_q;
        end else if (cfg_q.rate.ok) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign lead   = hit && !ph_q;
    assign trail  = hit && ph_q;
    assign active = act_q;
    assign bad    = act_q && !cfg_q.rate.ok;
    assign cpol_q = cfg_q.cpol;

    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (act_q && run) |=> $stable(cfg_q));
    assert_half_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (act_q && cfg_q.rate.ok) |-> (cnt_q <= hi_len));
    assert_valid_div_R3: assert property (@(posedge clk) disable iff (rst)
        (act_q && cfg_q.rate.ok) |-> (cfg_q.rate.div >= div_t'(EXT_MIN_DIV)));
    assert_stop_R6: assert property (@(posedge clk) disable iff (rst)
        !run |=> !act_q);
endmodule

// File: rtl/psc_wave.sv
module psc_wave (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic active,
    input  logic idle_in,
    input  logic cpol_q,
    input  logic lead,
    input  logic trail,
    output logic sck
);
    logic sck_q;

    always_ff @(posedge clk) begin
        if (rst || !run || !active) begin
            sck_q <= idle_in;
        end else if (lead) begin
            sck_q <= ~cpol_q;
        end else if (trail) begin
            sck_q <= cpol_q;
        end
    end

    assign sck = sck_q;

    assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !run |=> (sck_q == $past(idle_in)));
    assert_lead_level_R5: assert property (@(posedge clk) disable iff (rst)
        (lead && run) |=> (sck_q == !$past(cpol_q)));
    assert_trail_level_R5: assert property (@(posedge clk) disable iff (rst)
        (trail && run) |=> (sck_q == $past(cpol_q)));
endmodule

// File: rtl/sck_prescaler.sv
module sck_prescaler
    import sck_psc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               ext_fmt,
    input  logic [FIELD_W-1:0] rate_field,
    input  logic               idle_hi,
    output logic               lead_tick,
    output logic               trail_tick,
    output logic               sck,
    output logic               cfg_err
);
    rate_t dec_rate;
    logic  active;
    logic  cpol_q;

    psc_decode u_decode (
        .fmt   (fmt_e'(ext_fmt)),
        .field (rate_field),
        .rate  (dec_rate)
    );

    psc_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .rate_in (dec_rate),
        .cpol_in (idle_hi),
        .lead    (lead_tick),
        .trail   (trail_tick),
        .active  (active),
        .bad     (cfg_err),
        .cpol_q  (cpol_q)
    );

    psc_wave u_wave (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .active  (active),
        .idle_in (idle_hi),
        .cpol_q  (cpol_q),
        .lead    (lead_tick),
        .trail   (trail_tick),
        .sck     (sck)
    );

    assert_tick_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(lead_tick && trail_tick));
    assert_err_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (!lead_tick && !trail_tick));
endmodule

// File: tb/sck_prescaler_test.sv
module sck_prescaler_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic       ext_fmt = 1'b0;
    logic [7:0] rate_field = 8'h00;
    logic       idle_hi = 1'b0;
    logic       lead_tick, trail_tick, sck, cfg_err;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sck_prescaler uut (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .ext_fmt    (ext_fmt),
        .rate_field (rate_field),
        .idle_hi    (idle_hi),
        .lead_tick  (lead_tick),
        .trail_tick (trail_tick),
        .sck        (sck),
        .cfg_err    (cfg_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: got %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    function automatic int exp_div(input bit fmt, input logic [7:0] f);
        int e;
        if (!fmt) return 2 * int'(f[3:0]);
        e = 4 * int'(f[7]) + 2 * int'(f[6]) + int'(f[4]);
        return int'(f[3:0]) * (1 << e);
    endfunction

    function automatic bit exp_ok(input bit fmt, input logic [7:0] f);
        if (!fmt) return int'(f[3:0]) >= 2;
        return exp_div(fmt, f) >= 2;
    endfunction

    task automatic run_word(input bit fmt, input logic [7:0] f, input bit cp);
        int  d;
        int  lo;
        bit  ok;
        string mtag;
        d    = exp_div(fmt, f);
        lo   = d / 2;
        ok   = exp_ok(fmt, f);
        mtag = fmt ? "R2" : "R1";
        @(negedge clk);
        ext_fmt    = fmt;
        rate_field = f;
        idle_hi    = cp;
        run        = 1'b1;
        @(negedge clk);
        // R7: disturb every configuration input right after capture
        rate_field = ~f;
        ext_fmt    = ~fmt;
        idle_hi    = ~cp;
        if (ok) begin
            for (int c = 1; c <= d; c++) begin
                if (c > 1) @(negedge clk);
                chk(lead_tick == (c == lo), (c == lo) ? mtag : "R4 lead", lead_tick, c == lo);
                chk(trail_tick == (c == d), "R4 trail", trail_tick, c == d);
                chk(sck == ((c > lo) ? ~cp : cp), "R5 sck", sck, (c > lo) ? ~cp : cp);
                chk(cfg_err == 1'b0, "R3 err low", cfg_err, 0);
            end
            @(negedge clk);
            chk(sck == cp, "R7 sck back to captured idle", sck, cp);
        end else begin
            for (int c = 1; c <= 4; c++) begin
                if (c > 1) @(negedge clk);
                chk(cfg_err == 1'b1, "R3 err", cfg_err, 1);
                chk(!lead_tick && !trail_tick, "R3 ticks", lead_tick | trail_tick, 0);
                chk(sck == cp, "R3 sck", sck, cp);
            end
        end
        run = 1'b0;
        @(negedge clk);
        chk(sck == idle_hi, "R6 sck idle", sck, idle_hi);
        chk(!lead_tick && !trail_tick, "R6 ticks", lead_tick | trail_tick, 0);
        chk(cfg_err == 1'b0, "R6 err", cfg_err, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!lead_tick && !trail_tick, "R8 ticks", lead_tick | trail_tick, 0);
        chk(cfg_err == 1'b0, "R8 err", cfg_err, 0);
        chk(sck == idle_hi, "R8 sck", sck, idle_hi);
        idle_hi = 1'b1;
        @(negedge clk);
        chk(sck == 1'b1, "R8 sck follows idle", sck, 1);
        rst = 1'b0;
        for (int m = 0; m < 2; m++) begin
            for (int f = 0; f < 256; f++) begin
                run_word(m[0], 8'(f), m[0] ^ f[1]);
            end
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired: got %0d expected %0d", WATCHDOG, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule